// File: doc/BRIEF.md
# GPIO Expander with Change Interrupts

This block is an eight-pin general-purpose I/O port placed behind a small register bus. The bus has write enable, read enable, a two-bit address and eight-bit write and read data. Software sets each pin's direction, its output level and whether a change on that pin may raise an interrupt. The pin inputs cross into the clock domain through a two-flop synchronizer. Each enabled input pin is then compared against a stored reference level, and the block drives one level-sensitive interrupt that is high while any pin has an event pending.

Two clear behaviours are available. In transparent mode a pending event exists only while the pin differs from its reference level, so a pin that returns to its old level withdraws its own event. In latched mode the first difference is held, and the state register reports the level that caused it until software reads the state register.

Each four-pin group can instead be given to a modem channel. In that case three of the pins feed the channel's ring, carrier-detect and data-set-ready inputs, and the fourth pin is driven by the channel's data-terminal-ready output. The GPIO registers no longer act on that group. A self-clearing reset bit in the control word returns every register to its reset value.

Top module: `gpio_xpdr`

## Requirements
- R1: After the asynchronous reset, all four registers read 0, no pin is an output (`pin_oe_o` = 0) and `irq_o` is low.
- R2: The register map is: address 0 is direction (bit = 1 makes the pin an output); address 1 writes the output latch and reads pin state; address 2 is the per-pin interrupt enable; address 3 is control. Control bit 0 selects latched mode, bit 1 gives pins 7:4 to modem channel 1, bit 2 gives pins 3:0 to modem channel 0, and bit 3 is the reset. On a GPIO pin, `pin_oe_o` follows direction and `pin_o` follows the output latch. Control bits 7:3 read 0.
- R3: A state read of an input pin returns the pin level seen two clock edges earlier. For an output pin in a GPIO group it returns the output latch.
- R4: A pin whose enable bit is 0, that is set as an output, or that sits in a modem group never raises `irq_o`.
- R5: In transparent mode (control bit 0 = 0), a change on an enabled input raises `irq_o`. A read of address 1 clears it and makes the current level the new reference.
- R6: In transparent mode, if the pin returns to its reference level before the read, its event withdraws itself.
- R7: In latched mode, a change on an enabled input raises `irq_o`, and that pin's state bit reads the new level. A read of address 1 clears the event.
- R8: In latched mode, if the pin reverts before the read, `irq_o` stays high and the state bit keeps the level that caused the event.
- R9: With a group in modem mode, its pins at offsets 3, 2 and 0 are inputs that appear on `mdm_in_o` as {ring, carrier, ready}. Offset 1 is an output driven by that channel's `mdm_dtr_i`. Direction, output latch and enable have no effect on the group. While the channel's `mdm_ien_i` is set, `mdm_chg_o` pulses for one cycle when any of the three synchronized inputs changes.
- R10: With a group in GPIO mode, its `mdm_in_o` field is 0, its `mdm_chg_o` bit stays 0, and `mdm_dtr_i` does not reach the pin.
- R11: Writing control with bit 3 set clears every register and any pending event at that clock edge. Bit 3 reads back 0.
- R12: `irq_o` is high while at least one pin has an event pending, and low when none does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (a read of address 1 clears events) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| pin_i | input | 8 | Pin input levels, asynchronous |
| pin_o | output | 8 | Pin output levels |
| pin_oe_o | output | 8 | Pin output enables |
| irq_o | output | 1 | Change interrupt, active high level |
| mdm_dtr_i | input | 2 | Per-channel data-terminal-ready level to drive |
| mdm_ien_i | input | 2 | Per-channel modem change interrupt enable |
| mdm_in_o | output | 6 | Per channel {ring, carrier, ready}; channel n at bits 3n+2:3n |
| mdm_chg_o | output | 2 | Per-channel modem input change pulse |

## Verification
Some properties are checked on every cycle by the assertions. A held latched event keeps its pending flag and its reference level until a read or a disarm. A clear or a disarm always empties the latched flag. The reset bit empties every register. A modem group always shows the fixed pin directions, and a GPIO group keeps its modem outputs quiet.

Other behaviours show only in the bench scenarios. These include the two-edge synchronizer latency, the withdrawal of a transparent event when its pin reverts, and the way a read resets the reference level. The same holds for the OR across several pins as they revert one at a time, and for the interaction of reset and latching with events already pending.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  typedef enum logic [1:0] {
    REG_DIR   = 2'd0,
    REG_STATE = 2'd1,
    REG_IEN   = 2'd2,
    REG_CTRL  = 2'd3
  } gpx_reg_e;

  localparam int unsigned CTL_LATCH  = 0;
  localparam int unsigned CTL_MDM_HI = 1;
  localparam int unsigned CTL_MDM_LO = 2;
  localparam int unsigned CTL_SRST   = 3;
  localparam int unsigned CTL_W      = 3;

  // pin roles inside a modem group
  localparam int unsigned NIB_RI  = 3;
  localparam int unsigned NIB_CD  = 2;
  localparam int unsigned NIB_DTR = 1;
  localparam int unsigned NIB_DSR = 0;

  typedef struct packed {
    logic mdm_lo;
    logic mdm_hi;
    logic latch;
  } gpx_ctrl_t;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] dir_o,
  output logic [DW-1:0] out_o,
  output logic [DW-1:0] ien_o,
  output gpx_ctrl_t     ctrl_o,
  output logic          srst_o
);
  logic [DW-1:0] dir_q, out_q, ien_q;
  gpx_ctrl_t     ctrl_q;

  assign srst_o = wr_en_i && (gpx_reg_e'(addr_i) == REG_CTRL) && wdata_i[CTL_SRST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      ctrl_q <= '0;
    end else if (srst_o) begin
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      case (gpx_reg_e'(addr_i))
        REG_DIR:   dir_q <= wdata_i;
        REG_STATE: out_q <= wdata_i;
        REG_IEN:   ien_q <= wdata_i;
        REG_CTRL: begin
          ctrl_q.latch  <= wdata_i[CTL_LATCH];
          ctrl_q.mdm_hi <= wdata_i[CTL_MDM_HI];
          ctrl_q.mdm_lo <= wdata_i[CTL_MDM_LO];
        end
      endcase
    end
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign ien_o  = ien_q;
  assign ctrl_o = ctrl_q;

  a_r11_srst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> (dir_q == '0 && out_q == '0 && ien_q == '0 && ctrl_q == '0));
endmodule

// File: rtl/gpx_chg.sv
module gpx_chg #(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] sync_i,
  input  logic [NPIN-1:0] armed_i,
  input  logic            latch_i,
  input  logic            clr_i,
  output logic [NPIN-1:0] pend_o,
  output logic [NPIN-1:0] view_o
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic ref_q, held_q, diff;

    assign diff = sync_i[i] ^ ref_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ref_q  <= 1'b0;
        held_q <= 1'b0;
      end else begin
        // reference follows the pin while disarmed or on a clear
        if (!armed_i[i] || clr_i) ref_q <= sync_i[i];
        held_q <= latch_i & armed_i[i] & ~clr_i & (held_q | diff);
      end
    end

    assign pend_o[i] = latch_i ? held_q : (armed_i[i] & diff);
    // a held event reports the level that caused it: the inverse of the reference
    assign view_o[i] = held_q ? ~ref_q : sync_i[i];

    a_r8_latched_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (latch_i && armed_i[i] && !clr_i && held_q) |=> (held_q && $stable(ref_q)));
    a_r7_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !held_q);
    a_r4_disarmed_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !armed_i[i] |=> !held_q);
  end
endmodule

// File: rtl/gpx_nib_mux.sv
module gpx_nib_mux
  import gpx_pkg::*;
#(
  parameter  int unsigned NPIN = 8,
  localparam int unsigned NNIB = NPIN / 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NNIB-1:0]   mdm_mode_i,
  input  logic [NPIN-1:0]   dir_i,
  input  logic [NPIN-1:0]   out_i,
  input  logic [NPIN-1:0]   sync_i,
  input  logic [NNIB-1:0]   mdm_dtr_i,
  input  logic [NNIB-1:0]   mdm_ien_i,
  output logic [NPIN-1:0]   pin_o,
  output logic [NPIN-1:0]   pin_oe_o,
  output logic [NPIN-1:0]   gpio_msk_o,
  output logic [3*NNIB-1:0] mdm_in_o,
  output logic [NNIB-1:0]   mdm_chg_o
);
  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar n = 0; n < NNIB; n++) begin : g_nib
    localparam int unsigned B = 4 * n;
    logic [3:0] po_n, oe_n, sy_n, pv_n;

    assign sy_n = sync_i[B+3:B];
    assign pv_n = prev_q[B+3:B];

    always_comb begin
      if (mdm_mode_i[n]) begin
        po_n          = 4'b0;
        oe_n          = 4'b0;
        po_n[NIB_DTR] = mdm_dtr_i[n];
        oe_n[NIB_DTR] = 1'b1;
      end else begin
        po_n = out_i[B+3:B];
        oe_n = dir_i[B+3:B];
      end
    end

    assign pin_o[B+3:B]      = po_n;
    assign pin_oe_o[B+3:B]   = oe_n;
    assign gpio_msk_o[B+3:B] = {4{~mdm_mode_i[n]}};
    assign mdm_in_o[3*n+2:3*n] = mdm_mode_i[n] ?
                                 {sy_n[NIB_RI], sy_n[NIB_CD], sy_n[NIB_DSR]} : 3'b0;
    assign mdm_chg_o[n] = mdm_mode_i[n] & mdm_ien_i[n] &
                          ((sy_n[NIB_RI]  ^ pv_n[NIB_RI]) |
                           (sy_n[NIB_CD]  ^ pv_n[NIB_CD]) |
                           (sy_n[NIB_DSR] ^ pv_n[NIB_DSR]));
  end
endmodule

// File: rtl/gpio_xpdr.sv
module gpio_xpdr
  import gpx_pkg::*;
#(
  parameter  int unsigned NPIN = 8,
  localparam int unsigned NNIB = NPIN / 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [NPIN-1:0]   wdata_i,
  output logic [NPIN-1:0]   rdata_o,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   pin_o,
  output logic [NPIN-1:0]   pin_oe_o,
  output logic              irq_o,
  input  logic [NNIB-1:0]   mdm_dtr_i,
  input  logic [NNIB-1:0]   mdm_ien_i,
  output logic [3*NNIB-1:0] mdm_in_o,
  output logic [NNIB-1:0]   mdm_chg_o
);
  logic [NPIN-1:0] dir_q, out_q, ien_q, sync, pend, view, gpio_msk, armed, st_rd;
  logic [NNIB-1:0] mdm_mode;
  gpx_ctrl_t       ctrl_q;
  logic            srst, clr;

  gpx_regs #(.DW(NPIN)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .dir_o  (dir_q),
    .out_o  (out_q),
    .ien_o  (ien_q),
    .ctrl_o (ctrl_q),
    .srst_o (srst)
  );

  gpx_sync #(.W(NPIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync)
  );

  // control bit 1 owns the upper group, bit 2 the lower one
  assign mdm_mode = {ctrl_q.mdm_hi, ctrl_q.mdm_lo};

  gpx_nib_mux #(.NPIN(NPIN)) u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mdm_mode_i(mdm_mode),
    .dir_i     (dir_q),
    .out_i     (out_q),
    .sync_i    (sync),
    .mdm_dtr_i (mdm_dtr_i),
    .mdm_ien_i (mdm_ien_i),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o),
    .gpio_msk_o(gpio_msk),
    .mdm_in_o  (mdm_in_o),
    .mdm_chg_o (mdm_chg_o)
  );

  assign armed = gpio_msk & ~dir_q & ien_q;
  assign clr   = (rd_en_i && (gpx_reg_e'(addr_i) == REG_STATE)) || srst;

  gpx_chg #(.NPIN(NPIN)) u_chg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync),
    .armed_i(armed),
    .latch_i(ctrl_q.latch),
    .clr_i  (clr),
    .pend_o (pend),
    .view_o (view)
  );

  assign irq_o = |pend;

  always_comb begin
    for (int i = 0; i < NPIN; i++) st_rd[i] = (gpio_msk[i] & dir_q[i]) ? out_q[i] : view[i];
  end

  always_comb begin
    case (gpx_reg_e'(addr_i))
      REG_DIR:   rdata_o = dir_q;
      REG_STATE: rdata_o = st_rd;
      REG_IEN:   rdata_o = ien_q;
      REG_CTRL:  rdata_o = {{(NPIN-CTL_W){1'b0}}, ctrl_q};
    endcase
  end

  for (genvar n = 0; n < NNIB; n++) begin : g_chk
    a_r10_gpio_group_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mdm_mode[n] |-> (mdm_in_o[3*n+2:3*n] == 3'b0 && !mdm_chg_o[n]));
    a_r9_modem_group_dirs: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mdm_mode[n] |-> (pin_oe_o[4*n+3:4*n] == 4'b0010 && pin_o[4*n+NIB_DTR] == mdm_dtr_i[n]
                       && !armed[4*n+3] && !armed[4*n]));
  end
endmodule

// File: tb/gpio_xpdr_bench.sv
module gpio_xpdr_bench;
  localparam int CLK_PER = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00, pin_i = 8'h00;
  logic [1:0] mdm_dtr_i = 2'b00, mdm_ien_i = 2'b00;
  logic [7:0] rdata_o, pin_o, pin_oe_o;
  logic       irq_o;
  logic [5:0] mdm_in_o;
  logic [1:0] mdm_chg_o;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  gpio_xpdr u_gpio_xpdr (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o), .mdm_dtr_i(mdm_dtr_i),
    .mdm_ien_i(mdm_ien_i), .mdm_in_o(mdm_in_o), .mdm_chg_o(mdm_chg_o)
  );

  always #(CLK_PER/2) clk_i = ~clk_i;

  // ---------------- reference model ----------------
  logic [7:0] m_dir, m_out, m_ie, m_sync, m_prev, m_ref, m_pl;
  logic [2:0] m_ctl; // [0] latch, [1] upper modem, [2] lower modem
  logic [7:0] hist[$];

  function automatic logic [7:0] gmask();
    return {{4{~m_ctl[1]}}, {4{~m_ctl[2]}}};
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_dir = 0; m_out = 0; m_ie = 0; m_sync = 0; m_prev = 0; m_ref = 0; m_pl = 0; m_ctl = 0;
      hist = {8'h00};
    end else begin
      logic [7:0] armed, nref, npl;
      bit sr, clr;
      armed = gmask() & ~m_dir & m_ie;
      sr  = wr_en_i && addr_i == 2'd3 && wdata_i[3];
      clr = (rd_en_i && addr_i == 2'd1) || sr;
      nref = m_ref; npl = 0;
      for (int i = 0; i < 8; i++) begin
        if (!armed[i] || clr) nref[i] = m_sync[i];
        npl[i] = m_ctl[0] && armed[i] && !clr && (m_pl[i] || (m_sync[i] != m_ref[i]));
      end
      m_prev = m_sync;
      m_sync = hist.pop_front();
      hist.push_back(pin_i);
      if (sr) begin
        m_dir = 0; m_out = 0; m_ie = 0; m_ctl = 0;
      end else if (wr_en_i) begin
        case (addr_i)
          2'd0: m_dir = wdata_i;
          2'd1: m_out = wdata_i;
          2'd2: m_ie  = wdata_i;
          2'd3: m_ctl = wdata_i[2:0];
        endcase
      end
      m_ref = nref; m_pl = npl;
    end
  end

  function automatic logic [32:0] expected();
    logic [7:0] gm, armed, pend, po, oe, rd;
    logic [5:0] mi;
    logic [1:0] mc;
    gm = gmask();
    armed = gm & ~m_dir & m_ie;
    for (int i = 0; i < 8; i++)
      pend[i] = m_ctl[0] ? m_pl[i] : (armed[i] && m_sync[i] != m_ref[i]);
    for (int n = 0; n < 2; n++) begin
      bit md;
      md = (n == 1) ? m_ctl[1] : m_ctl[2];
      for (int k = 0; k < 4; k++) begin
        po[4*n+k] = md ? ((k == 1) ? mdm_dtr_i[n] : 1'b0) : m_out[4*n+k];
        oe[4*n+k] = md ? (k == 1) : m_dir[4*n+k];
      end
      mi[3*n +: 3] = md ? {m_sync[4*n+3], m_sync[4*n+2], m_sync[4*n]} : 3'b0;
      mc[n] = md && mdm_ien_i[n] &&
              ((m_sync[4*n+3] ^ m_prev[4*n+3]) || (m_sync[4*n+2] ^ m_prev[4*n+2]) ||
               (m_sync[4*n] ^ m_prev[4*n]));
    end
    case (addr_i)
      2'd0: rd = m_dir;
      2'd1: for (int i = 0; i < 8; i++)
              rd[i] = (gm[i] && m_dir[i]) ? m_out[i] : (m_pl[i] ? ~m_ref[i] : m_sync[i]);
      2'd2: rd = m_ie;
      default: rd = {5'b0, m_ctl};
    endcase
    return {|pend, po, oe, rd, mi, mc};
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic [32:0] act, exp;
      act = {irq_o, pin_o, pin_oe_o, rdata_o, mdm_in_o, mdm_chg_o};
      exp = expected();
      n_cmp++;
      if (act !== exp) begin
        n_bad++;
        $display("FAIL %s cycle compare: actual=%h expected=%h", cur_req, act, exp);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s directed: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk_i); #1;
    wr_en_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 0;
  endtask

  task automatic rd_state();
    @(posedge clk_i); #1;
    rd_en_i = 1; addr_i = 2'd1;
    @(posedge clk_i); #1;
    rd_en_i = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    @(posedge clk_i); #1;
    addr_i = a;
    @(negedge clk_i);
    v = rdata_o;
  endtask

  task automatic set_pin(input logic [7:0] v);
    @(posedge clk_i); #1;
    pin_i = v;
  endtask

  initial begin
    #(CLK_PER * 100000);
    n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    step(3);
    rst_ni = 1;
    // R1
    cur_req = "R1";
    for (int a = 0; a < 4; a++) begin peek(a[1:0], v); chk("R1", v, 0); end
    chk("R1", {irq_o, pin_oe_o}, 0);

    // R2
    cur_req = "R2";
    wr(0, 8'hF0); wr(1, 8'hA5);
    peek(0, v); chk("R2", v, 8'hF0);
    peek(1, v); chk("R2", v, 8'hA0);
    chk("R2", {pin_oe_o, pin_o}, 16'hF0A5);
    wr(3, 8'hF0); peek(3, v); chk("R2", v, 8'h00);
    wr(2, 8'h3C); peek(2, v); chk("R2", v, 8'h3C);

    // R3, R4
    cur_req = "R3";
    wr(0, 8'h00); wr(2, 8'h00);
    addr_i = 2'd1;
    set_pin(8'h5A);
    @(negedge clk_i); chk("R3", rdata_o, 8'h00);
    @(negedge clk_i); chk("R3", rdata_o, 8'h00);
    @(negedge clk_i); chk("R3", rdata_o, 8'h5A);
    cur_req = "R4";
    set_pin(8'hA5); step(4); chk("R4", irq_o, 0);
    wr(0, 8'hFF); wr(2, 8'hFF);
    set_pin(8'h5A); step(4); chk("R4", irq_o, 0);
    wr(0, 8'h00); step(3); chk("R4", irq_o, 0);

    // R5
    cur_req = "R5";
    set_pin(8'h5B); step(3); chk("R5", irq_o, 1);
    rd_state(); @(negedge clk_i); chk("R5", irq_o, 0);

    // R6
    cur_req = "R6";
    set_pin(8'h5F); step(3); chk("R6", irq_o, 1);
    set_pin(8'h5B); step(3); chk("R6", irq_o, 0);

    // R12
    cur_req = "R12";
    set_pin(8'hDA); step(3); chk("R12", irq_o, 1);
    set_pin(8'h5A); step(3); chk("R12", irq_o, 1);
    set_pin(8'h5B); step(3); chk("R12", irq_o, 0);

    // R7, R8
    cur_req = "R7";
    wr(3, 8'h01);
    set_pin(8'h4B); step(3); chk("R7", irq_o, 1);
    peek(1, v); chk("R7", v, 8'h4B);
    cur_req = "R8";
    set_pin(8'h5B); step(3); chk("R8", irq_o, 1);
    peek(1, v); chk("R8", v, 8'h4B);
    cur_req = "R7";
    rd_state(); @(negedge clk_i); chk("R7", irq_o, 0);
    peek(1, v); chk("R7", v, 8'h5B);

    // R11
    cur_req = "R11";
    set_pin(8'h5A); step(3); chk("R11", irq_o, 1);
    wr(3, 8'h09);
    @(negedge clk_i); chk("R11", irq_o, 0);
    peek(3, v); chk("R11", v, 8'h00);
    peek(2, v); chk("R11", v, 8'h00);

    // R9
    cur_req = "R9";
    mdm_dtr_i = 2'b10; mdm_ien_i = 2'b11;
    wr(3, 8'h02); wr(0, 8'hFF); wr(2, 8'hFF);
    @(negedge clk_i); chk("R9", {pin_oe_o, pin_o}, 16'h2F20);
    set_pin(8'hDA);
    @(negedge clk_i); @(negedge clk_i); @(negedge clk_i);
    chk("R9", mdm_chg_o, 2'b10);
    chk("R9", mdm_in_o, 6'b111_000);
    @(negedge clk_i); chk("R9", mdm_chg_o, 2'b00);
    chk("R9", irq_o, 0);

    // R10
    cur_req = "R10";
    mdm_dtr_i = 2'b11;
    set_pin(8'hDB); step(4);
    chk("R10", {mdm_in_o[2:0], mdm_chg_o[0]}, 0);
    @(negedge clk_i); chk("R10", pin_o[1], 0);

    step(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule